// File: doc/BRIEF.md
# Bus Burst Address Generator

This block produces the transfer address for each beat of a pipelined system bus burst. A bus agent presents a transfer type, a burst type, a transfer size and, on the first beat, a start address. The block registers that start address. On every later accepted sequential beat it computes the next address on its own, so the agent never has to work it out.

Each burst class has its own next-address path, and a mux selects one path by burst type. Incrementing bursts add a step set by the transfer size: one byte shifted left by the size code. Wrapping bursts add the same step but keep every address bit above the wrap boundary. The boundary is the beat count times the bytes per beat. Fixed-length bursts also load a count of remaining beats and raise a last-beat flag on their final beat. Idle, busy and stalled cycles leave the address and the count untouched.

Top module: `ahb_burst_addr_gen`

## Requirements
- R1: While rst_ni is low, haddr_o is 0, beats_left_o is 0 and last_beat_o is 0.
- R2: An accepted NONSEQ beat (hready_i=1, htrans_i=2'b10) makes haddr_o equal start_addr_i one clock later, whatever the burst type and size. Transfer types: 00 idle, 01 busy, 10 nonsequential, 11 sequential. Burst types: 000 single, 001 undefined-length incrementing, 010 wrap-4, 011 incr-4, 100 wrap-8, 101 incr-8, 110 wrap-16, 111 incr-16.
- R3: A single burst (000) keeps haddr_o at the start address independent of hsize_i, holds beats_left_o at 0 and drives last_beat_o high; a following SEQ beat leaves haddr_o unchanged.
- R4: On each accepted SEQ beat of an incrementing burst, haddr_o grows by 2**hsize_i bytes, using the size latched at the NONSEQ beat (000 adds 1, 001 adds 2, 010 adds 4, 011 adds 8, 100 adds 16, 101 adds 32, 110 adds 64, 111 adds 128).
- R5: An undefined-length incrementing burst never wraps, has no beat limit and never raises last_beat_o.
- R6: A fixed-length burst of N beats loads beats_left_o with N-1 at its NONSEQ beat and lowers it by one on each accepted SEQ beat. last_beat_o is high exactly when beats_left_o reaches 0.
- R7: On a wrapping burst of N beats at size s, the bits of haddr_o at and above position log2(N)+s stay unchanged, and the low bits advance by 2**s modulo N*2**s. For example, wrap-4 with word beats from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R8: An idle beat, a busy beat, or any cycle with hready_i low leaves haddr_o and beats_left_o unchanged.
- R9: A SEQ beat is ignored, leaving haddr_o and beats_left_o unchanged, when it follows the final beat of a fixed-length burst or an accepted idle beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| htrans_i | input | 2 | Transfer type of the current beat |
| hburst_i | input | 3 | Burst type, sampled on NONSEQ |
| hsize_i | input | 3 | Transfer size code, sampled on NONSEQ |
| hready_i | input | 1 | Beat accepted when high |
| start_addr_i | input | 32 | Start address, loaded on NONSEQ |
| haddr_o | output | 32 | Registered current beat address |
| beats_left_o | output | 4 | Beats remaining after the current one in a fixed burst |
| last_beat_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The hardest case to reach is the wrap-around point inside a wrapping burst. In that beat the carry out of the boundary field must be dropped while the upper bits stay put. Where it falls depends on both the latched size and the burst length. The stimulus therefore starts wrapping bursts at offsets just below the boundary, with byte, halfword, word and doubleword beats. It also puts stalls and busy beats inside a counted burst, then sends extra SEQ beats after the last beat and after an idle beat. These show that the counter and the address freeze rather than run on.

// File: rtl/ahb_ag_pkg.sv
package ahb_ag_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001,
    BU_WRAP4  = 3'b010,
    BU_INCR4  = 3'b011,
    BU_WRAP8  = 3'b100,
    BU_INCR8  = 3'b101,
    BU_WRAP16 = 3'b110,
    BU_INCR16 = 3'b111
  } hburst_e;

  // beats in a burst; undefined-length counts as one (no limit tracked)
  function automatic logic [4:0] burst_beats(logic [2:0] b);
    case (b)
      BU_WRAP4, BU_INCR4:   burst_beats = 5'd4;
      BU_WRAP8, BU_INCR8:   burst_beats = 5'd8;
      BU_WRAP16, BU_INCR16: burst_beats = 5'd16;
      default:              burst_beats = 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/ahb_ag_next.sv
module ahb_ag_next #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        burst_i,
  input  logic [2:0]        size_i,
  output logic [ADDR_W-1:0] nxt_o
);
  import ahb_ag_pkg::*;

  localparam int N_WRAP = 3;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] wrap_nxt [N_WRAP];

  assign step = ADDR_W'(1) << size_i;
  assign sum  = addr_i + step;

  // one wrap path per length: 4, 8, 16 beats
  for (genvar g = 0; g < N_WRAP; g++) begin : g_wrap
    localparam int LOG_BEATS = g + 2;
    logic [ADDR_W-1:0] mask;
    assign mask = (ADDR_W'(1) << (5'(LOG_BEATS) + 5'(size_i))) - ADDR_W'(1);
    assign wrap_nxt[g] = (addr_i & ~mask) | (sum & mask);
  end

  always_comb begin
    case (burst_i)
      BU_SINGLE:                              nxt_o = addr_i;
      BU_WRAP4:                               nxt_o = wrap_nxt[0];
      BU_WRAP8:                               nxt_o = wrap_nxt[1];
      BU_WRAP16:                              nxt_o = wrap_nxt[2];
      default:                                nxt_o = sum;
    endcase
  end
endmodule

// File: rtl/ahb_ag_beat_cnt.sv
module ahb_ag_beat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ahb_burst_addr_gen.sv
module ahb_burst_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   htrans_i,
  input  logic [2:0]                   hburst_i,
  input  logic [2:0]                   hsize_i,
  input  logic                         hready_i,
  input  logic [ADDR_W-1:0]            start_addr_i,
  output logic [ADDR_W-1:0]            haddr_o,
  output logic [$clog2(MAX_BEATS)-1:0] beats_left_o,
  output logic                         last_beat_o
);
  import ahb_ag_pkg::*;

  localparam int CNT_W = $clog2(MAX_BEATS);

  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [2:0]        burst_q, size_q;
  logic              active_q;
  logic              is_nonseq, is_seq, is_idle, seq_ok, cnt_zero;
  logic [4:0]        load_beats;

  assign is_nonseq = hready_i && (htrans_i == TR_NONSEQ);
  assign is_seq    = hready_i && (htrans_i == TR_SEQ);
  assign is_idle   = hready_i && (htrans_i == TR_IDLE);
  assign seq_ok    = is_seq && active_q && ((burst_q == BU_INCR) || !cnt_zero);

  ahb_ag_next #(.ADDR_W(ADDR_W)) u_next (
    .addr_i (addr_q),
    .burst_i(burst_q),
    .size_i (size_q),
    .nxt_o  (addr_nxt)
  );

  assign load_beats = burst_beats(hburst_i) - 5'd1;

  ahb_ag_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (is_nonseq),
    .load_val_i(CNT_W'(load_beats)),
    .dec_i     (seq_ok && burst_q != BU_INCR),
    .cnt_o     (beats_left_o),
    .zero_o    (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      burst_q  <= BU_SINGLE;
      size_q   <= '0;
      active_q <= 1'b0;
    end else if (is_nonseq) begin
      addr_q   <= start_addr_i;
      burst_q  <= hburst_i;
      size_q   <= hsize_i;
      active_q <= 1'b1;
    end else begin
      if (seq_ok)  addr_q   <= addr_nxt;
      if (is_idle) active_q <= 1'b0;
    end
  end

  assign haddr_o     = addr_q;
  assign last_beat_o = active_q && (burst_q != BU_INCR) && cnt_zero;
endmodule

// File: rtl/ahb_ag_chk.sv
module ahb_ag_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        htrans_i,
  input logic              hready_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] haddr_o,
  input logic [CNT_W-1:0]  beats_left_o,
  input logic              last_beat_o,
  input logic [2:0]        burst_q,
  input logic [2:0]        size_q,
  input logic              active_q
);
  logic              acc_seq, is_wrap, is_fixed;
  logic [ADDR_W-1:0] step, wmask;
  logic [4:0]        nbeats;

  assign acc_seq  = hready_i && htrans_i == 2'b11 && active_q;
  assign is_wrap  = burst_q == 3'b010 || burst_q == 3'b100 || burst_q == 3'b110;
  assign is_fixed = burst_q != 3'b001;
  assign step     = ADDR_W'(1) << size_q;
  assign nbeats   = (burst_q == 3'b010) ? 5'd4 : (burst_q == 3'b100) ? 5'd8 : 5'd16;
  assign wmask    = (ADDR_W'(nbeats) << size_q) - ADDR_W'(1);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && htrans_i == 2'b10) |=> haddr_o == $past(start_addr_i));

  p_incr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_seq && burst_q == 3'b001) |=> haddr_o == $past(haddr_o) + $past(step));

  p_no_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && burst_q == 3'b001) |-> !last_beat_o);

  p_cnt_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_seq && is_fixed && beats_left_o != '0 && htrans_i == 2'b11)
      |=> beats_left_o == $past(beats_left_o) - CNT_W'(1));

  p_last_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o |-> beats_left_o == '0);

  p_wrap_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_seq && is_wrap && beats_left_o != '0)
      |=> (haddr_o & ~$past(wmask)) == ($past(haddr_o) & ~$past(wmask)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> ($stable(haddr_o) && $stable(beats_left_o)));

  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && htrans_i == 2'b11 && last_beat_o) |=> $stable(haddr_o));
endmodule

bind ahb_burst_addr_gen ahb_ag_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .htrans_i    (htrans_i),
  .hready_i    (hready_i),
  .start_addr_i(start_addr_i),
  .haddr_o     (haddr_o),
  .beats_left_o(beats_left_o),
  .last_beat_o (last_beat_o),
  .burst_q     (burst_q),
  .size_q      (size_q),
  .active_q    (active_q)
);

// File: tb/ahb_burst_addr_gen_tb.sv
module ahb_burst_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hburst = 3'b000;
  logic [2:0]  hsize = 3'b000;
  logic        hready = 1'b1;
  logic [31:0] start_addr = '0;
  logic [31:0] haddr;
  logic [3:0]  beats_left;
  logic        last_beat;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ahb_burst_addr_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .htrans_i    (htrans),
    .hburst_i    (hburst),
    .hsize_i     (hsize),
    .hready_i    (hready),
    .start_addr_i(start_addr),
    .haddr_o     (haddr),
    .beats_left_o(beats_left),
    .last_beat_o (last_beat)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic beat(logic [1:0] t, logic [2:0] b, logic [2:0] s, logic [31:0] a, logic r);
    @(negedge clk);
    htrans = t; hburst = b; hsize = s; start_addr = a; hready = r;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 addr", haddr, 32'h0);
    check("R1 beats", 32'(beats_left), 32'h0);
    check("R1 last", 32'(last_beat), 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_single();
    beat(2'b10, 3'b000, 3'd2, 32'h1234_5677, 1'b1);
    check("R3 addr", haddr, 32'h1234_5677);
    check("R3 last", 32'(last_beat), 32'h1);
    check("R3 beats", 32'(beats_left), 32'h0);
    beat(2'b11, 3'b000, 3'd5, 32'hDEAD_0000, 1'b1);
    check("R3 seq ignored", haddr, 32'h1234_5677);
  endtask

  task automatic t_incr_sizes();
    for (int s = 0; s < 8; s++) begin
      beat(2'b10, 3'b001, 3'(s), 32'h100, 1'b1);
      check("R2 load", haddr, 32'h100);
      for (int k = 1; k <= 3; k++) begin
        beat(2'b11, 3'b001, 3'd0, 32'h0, 1'b1);
        check("R4 step", haddr, 32'h100 + 32'(k) * (32'd1 << s));
      end
    end
  endtask

  task automatic t_incr_unbounded();
    beat(2'b10, 3'b001, 3'd2, 32'h3F8, 1'b1);
    for (int k = 1; k <= 20; k++) begin
      beat(2'b11, 3'b001, 3'd2, 32'h0, 1'b1);
      check("R5 addr", haddr, 32'h3F8 + 32'(4 * k));
      check("R5 last", 32'(last_beat), 32'h0);
    end
  endtask

  task automatic t_fixed(logic [2:0] b, int n, logic [2:0] s, logic [31:0] a0);
    beat(2'b10, b, s, a0, 1'b1);
    check("R6 load beats", 32'(beats_left), 32'(n - 1));
    for (int k = 1; k < n; k++) begin
      beat(2'b11, b, s, 32'h0, 1'b1);
      check("R6 addr", haddr, a0 + 32'(k) * (32'd1 << s));
      check("R6 beats", 32'(beats_left), 32'(n - 1 - k));
      check("R6 last", 32'(last_beat), 32'(k == n - 1));
    end
    beat(2'b11, b, s, 32'h0, 1'b1);
    check("R9 after last addr", haddr, a0 + 32'(n - 1) * (32'd1 << s));
    check("R9 after last beats", 32'(beats_left), 32'h0);
  endtask

  task automatic t_wrap(logic [2:0] b, int n, logic [2:0] s, logic [31:0] a0);
    logic [31:0] bound, base, off;
    bound = 32'(n) << s;
    base  = a0 & ~(bound - 1);
    off   = a0 & (bound - 1);
    beat(2'b10, b, s, a0, 1'b1);
    check("R7 first", haddr, a0);
    for (int k = 1; k < n; k++) begin
      beat(2'b11, b, s, 32'h0, 1'b1);
      check("R7 wrap", haddr, base + ((off + 32'(k) * (32'd1 << s)) % bound));
    end
    check("R7 last", 32'(last_beat), 32'h1);
  endtask

  task automatic t_wrap_example();
    logic [31:0] exp [4] = '{32'h34, 32'h38, 32'h3C, 32'h30};
    beat(2'b10, 3'b010, 3'd2, 32'h34, 1'b1);
    check("R7 ex0", haddr, exp[0]);
    for (int k = 1; k < 4; k++) begin
      beat(2'b11, 3'b010, 3'd2, 32'h0, 1'b1);
      check("R7 ex", haddr, exp[k]);
    end
  endtask

  task automatic t_hold();
    beat(2'b10, 3'b011, 3'd2, 32'h2000, 1'b1);
    beat(2'b11, 3'b011, 3'd2, 32'h0, 1'b1);
    check("R8 pre", haddr, 32'h2004);
    beat(2'b11, 3'b011, 3'd2, 32'h0, 1'b0);
    check("R8 stall addr", haddr, 32'h2004);
    check("R8 stall beats", 32'(beats_left), 32'd2);
    beat(2'b10, 3'b001, 3'd0, 32'h9999, 1'b0);
    check("R8 stalled nonseq", haddr, 32'h2004);
    beat(2'b01, 3'b011, 3'd2, 32'h0, 1'b1);
    check("R8 busy addr", haddr, 32'h2004);
    check("R8 busy beats", 32'(beats_left), 32'd2);
    beat(2'b11, 3'b011, 3'd2, 32'h0, 1'b1);
    check("R8 resume", haddr, 32'h2008);
    check("R8 resume beats", 32'(beats_left), 32'd1);
  endtask

  task automatic t_idle_end();
    beat(2'b10, 3'b001, 3'd1, 32'h500, 1'b1);
    beat(2'b11, 3'b001, 3'd1, 32'h0, 1'b1);
    check("R5 pre idle", haddr, 32'h502);
    beat(2'b00, 3'b001, 3'd1, 32'h0, 1'b1);
    check("R8 idle addr", haddr, 32'h502);
    beat(2'b11, 3'b001, 3'd1, 32'h0, 1'b1);
    check("R9 seq after idle", haddr, 32'h502);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_incr_sizes();
    t_incr_unbounded();
    t_fixed(3'b011, 4, 3'd1, 32'h1000);
    t_fixed(3'b101, 8, 3'd2, 32'h2FF0);
    t_fixed(3'b111, 16, 3'd0, 32'hFFF8);
    t_wrap_example();
    t_wrap(3'b010, 4, 3'd3, 32'h118);
    t_wrap(3'b100, 8, 3'd1, 32'h2E);
    t_wrap(3'b110, 16, 3'd0, 32'h7B);
    t_wrap(3'b110, 16, 3'd2, 32'hABC4);
    t_hold();
    t_idle_end();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule